// File: doc/BRIEF.md
# Sample-Fetch DMA Stall Arbiter

This block sits beside a processor core and an audio sample channel. When the channel needs its next sample byte it raises a fetch request with the byte's address. The arbiter then holds the processor stalled for a number of cycles chosen from what the bus is doing at that moment, and reads the byte from memory in the last stalled cycle. In the cycle after the stall it hands the byte to the channel's sample buffer with a one-cycle load pulse.

The stall length depends on two things. The first is whether the sprite copy engine is running and how many bytes it still has to move. The second is whether the processor is in a write cycle, and if so whether that write targets the address that starts the sprite copy. The sprite state takes priority over the processor write state.

A request that arrives while a stall is already running waits in a single pending slot. Its stall follows the current one with no gap. The length and address of the waiting request are frozen at the moment it arrived.

Top module: `fetch_stall_arb`

## Requirements
- R1: While reset is asserted and afterwards until the first request, `stall`, `mem_rd` and `buf_load` are low.
- R2: A request sampled at a clock edge while `stall` is low, with no processor write and the sprite engine idle, makes `stall` high for exactly 4 cycles, starting in the cycle after that edge.
- R3: With the sprite engine idle and `cpu_wr` high with `cpu_wr_addr` equal to 0x4014, the stall is 2 cycles.
- R4: With the sprite engine idle and `cpu_wr` high to any other address, the stall is 3 cycles.
- R5: With `spr_busy` high and `spr_left` equal to 2, the stall is 1 cycle, whatever the processor write state.
- R6: With `spr_busy` high and `spr_left` equal to 1, the stall is 3 cycles.
- R7: With `spr_busy` high and `spr_left` equal to any value other than 1 or 2, the stall is 2 cycles.
- R8: `mem_rd` is high only in the last cycle of each stall. In that cycle `mem_addr` equals the `fetch_addr` captured with the request being served.
- R9: `buf_load` is high for the single cycle after each stall's last cycle. In that cycle `buf_byte` equals the `mem_data` value present during that last stall cycle.
- R10: A request sampled while a stall runs, with the pending slot empty, is served right after the current stall, with no idle cycle between them. Its length and address are those present when it was sampled.
- R11: A request sampled while a stall runs and the pending slot is already full is discarded. It produces no stall and no load pulse.
- R12: While `stall` is low and `fetch_req` is low, `stall` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Sample channel asks for one byte (sampled each edge) |
| fetch_addr | input | 16 | Address of the requested byte |
| cpu_wr | input | 1 | Processor is in a write cycle |
| cpu_wr_addr | input | 16 | Address of the current processor write |
| spr_busy | input | 1 | Sprite copy engine is running |
| spr_left | input | 9 | Bytes the sprite engine still has to move |
| mem_data | input | 8 | Read data for `mem_addr` |
| stall | output | 1 | Processor halted for the sample fetch |
| mem_rd | output | 1 | Read strobe, last stall cycle |
| mem_addr | output | 16 | Address of the byte being fetched |
| buf_load | output | 1 | One-cycle pulse loading the sample buffer |
| buf_byte | output | 8 | Byte for the sample buffer |

## Verification
A corrupted down-counter shows at the ports as a `stall` window of the wrong width. The `mem_rd` strobe also lands in the wrong cycle and the load pulse is misplaced, so every stall cycle is compared with its expected value and the error appears within one request. A bad pending slot shows up when two stalls are chained: a gap or overlap appears between the two windows, the second stall has the wrong width, the second address is wrong, or a discarded request produces an extra window within a few cycles after the chain. A wrong captured byte shows up in the very cycle `buf_load` rises.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

   typedef enum logic [2:0] {
      CLS_QUIET,
      CLS_WR_TRIG,
      CLS_WR_OTHER,
      CLS_SPR_TWO,
      CLS_SPR_ONE,
      CLS_SPR_MID
   } fetch_cls_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fsa_classify.sv
module fsa_classify
   import fsa_pkg::*;
#(
   parameter int                ADDR_W       = 16,
   parameter int                LEFT_W       = 9,
   parameter logic [ADDR_W-1:0] TRIG_ADDR    = 16'h4014,
   parameter int                CNT_W        = 3,
   parameter int                LEN_QUIET    = 4,
   parameter int                LEN_WR_TRIG  = 2,
   parameter int                LEN_WR_OTHER = 3,
   parameter int                LEN_SPR_TWO  = 1,
   parameter int                LEN_SPR_ONE  = 3,
   parameter int                LEN_SPR_MID  = 2
) (
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              spr_busy,
   input  logic [LEFT_W-1:0] spr_left,
   output logic [CNT_W-1:0]  len
);

   fetch_cls_e cls;

   always_comb begin
      if (spr_busy) begin
         if (spr_left == LEFT_W'(2))      cls = CLS_SPR_TWO;
         else if (spr_left == LEFT_W'(1)) cls = CLS_SPR_ONE;
         else                             cls = CLS_SPR_MID;
      end else if (cpu_wr) begin
         if (wr_addr == TRIG_ADDR)        cls = CLS_WR_TRIG;
         else                             cls = CLS_WR_OTHER;
      end else begin
         cls = CLS_QUIET;
      end
   end

   always_comb begin
      case (cls)
         CLS_WR_TRIG:  len = CNT_W'(LEN_WR_TRIG);
         CLS_WR_OTHER: len = CNT_W'(LEN_WR_OTHER);
         CLS_SPR_TWO:  len = CNT_W'(LEN_SPR_TWO);
         CLS_SPR_ONE:  len = CNT_W'(LEN_SPR_ONE);
         CLS_SPR_MID:  len = CNT_W'(LEN_SPR_MID);
         default:      len = CNT_W'(LEN_QUIET);
      endcase
   end

endmodule

// File: rtl/fsa_pend_slot.sv
module fsa_pend_slot #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              drain,
   input  logic [CNT_W-1:0]  in_len,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              full,
   output logic [CNT_W-1:0]  len,
   output logic [ADDR_W-1:0] addr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         len  <= '0;
         addr <= '0;
      end else begin
         if (load) begin
            full <= 1'b1;
            len  <= in_len;
            addr <= in_addr;
         end else if (drain) begin
            full <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/fsa_stall_core.sv
module fsa_stall_core #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  start_len,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [DATA_W-1:0] mem_data,
   output logic              busy,
   output logic              last,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              buf_load,
   output logic [DATA_W-1:0] buf_byte
);

   logic [CNT_W-1:0] cnt;

   assign busy = (cnt != '0);
   assign last = (cnt == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         cur_addr <= '0;
      end else if (start) begin
         cnt      <= start_len;
         cur_addr <= start_addr;
      end else if (busy) begin
         cnt      <= cnt - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_load <= 1'b0;
         buf_byte <= '0;
      end else begin
         buf_load <= last;
         if (last) buf_byte <= mem_data;
      end
   end

endmodule

// File: rtl/fetch_stall_arb.sv
module fetch_stall_arb
   import fsa_pkg::*;
#(
   parameter int                ADDR_W       = 16,
   parameter int                DATA_W       = 8,
   parameter int                LEFT_W       = 9,
   parameter logic [ADDR_W-1:0] TRIG_ADDR    = 16'h4014,
   parameter int                LEN_QUIET    = 4,
   parameter int                LEN_WR_TRIG  = 2,
   parameter int                LEN_WR_OTHER = 3,
   parameter int                LEN_SPR_TWO  = 1,
   parameter int                LEN_SPR_ONE  = 3,
   parameter int                LEN_SPR_MID  = 2,
   parameter bit                PEND_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_wr_addr,
   input  logic              spr_busy,
   input  logic [LEFT_W-1:0] spr_left,
   input  logic [DATA_W-1:0] mem_data,
   output logic              stall,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              buf_load,
   output logic [DATA_W-1:0] buf_byte
);

   localparam int MAX_LEN = imax(imax(imax(LEN_QUIET, LEN_WR_TRIG), imax(LEN_WR_OTHER, LEN_SPR_TWO)),
                                 imax(LEN_SPR_ONE, LEN_SPR_MID));
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   initial begin
      assert (ADDR_W > 0 && DATA_W > 0 && LEFT_W > 1)
         else $error("fetch_stall_arb: bad width parameter");
      assert (LEN_QUIET >= 1 && LEN_WR_TRIG >= 1 && LEN_WR_OTHER >= 1 &&
              LEN_SPR_TWO >= 1 && LEN_SPR_ONE >= 1 && LEN_SPR_MID >= 1)
         else $error("fetch_stall_arb: every stall length must be at least one cycle");
   end

   logic [CNT_W-1:0]  req_len;
   logic              busy, last;
   logic              pend_full, pend_load, pend_drain;
   logic [CNT_W-1:0]  pend_len;
   logic [ADDR_W-1:0] pend_addr;
   logic              start;
   logic [CNT_W-1:0]  start_len;
   logic [ADDR_W-1:0] start_addr;

   fsa_classify #(
      .ADDR_W(ADDR_W), .LEFT_W(LEFT_W), .TRIG_ADDR(TRIG_ADDR), .CNT_W(CNT_W),
      .LEN_QUIET(LEN_QUIET), .LEN_WR_TRIG(LEN_WR_TRIG), .LEN_WR_OTHER(LEN_WR_OTHER),
      .LEN_SPR_TWO(LEN_SPR_TWO), .LEN_SPR_ONE(LEN_SPR_ONE), .LEN_SPR_MID(LEN_SPR_MID)
   ) u_cls (
      .cpu_wr   (cpu_wr),
      .wr_addr  (cpu_wr_addr),
      .spr_busy (spr_busy),
      .spr_left (spr_left),
      .len      (req_len)
   );

   // Serve the waiting request first; a new one starts directly only when
   // nothing waits and the engine is free or in its final cycle.
   always_comb begin
      if (last) start = pend_full | fetch_req;
      else      start = ~busy & fetch_req;
      start_len  = pend_full ? pend_len  : req_len;
      start_addr = pend_full ? pend_addr : fetch_addr;
      pend_drain = last & pend_full;
      pend_load  = fetch_req & busy & ((~last & ~pend_full) | (last & pend_full));
   end

   generate
      if (PEND_EN) begin : g_slot
         fsa_pend_slot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (pend_load),
            .drain   (pend_drain),
            .in_len  (req_len),
            .in_addr (fetch_addr),
            .full    (pend_full),
            .len     (pend_len),
            .addr    (pend_addr)
         );
      end else begin : g_noslot
         assign pend_full = 1'b0;
         assign pend_len  = '0;
         assign pend_addr = '0;
      end
   endgenerate

   fsa_stall_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_len  (start_len),
      .start_addr (start_addr),
      .mem_data   (mem_data),
      .busy       (busy),
      .last       (last),
      .cur_addr   (mem_addr),
      .buf_load   (buf_load),
      .buf_byte   (buf_byte)
   );

   assign stall  = busy;
   assign mem_rd = last;

endmodule

// File: rtl/fsa_checker.sv
module fsa_checker #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_req,
   input logic              stall,
   input logic              mem_rd,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              buf_load,
   input logic [DATA_W-1:0] buf_byte,
   input logic [DATA_W-1:0] mem_data,
   input logic              pend_full
);

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && fetch_req) |=> stall);

   assert_rd_inside_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> stall);

   assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !mem_rd) |=> (stall && $stable(mem_addr)));

   assert_load_after_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> buf_load);

   assert_load_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      buf_load |-> ($past(mem_rd) && buf_byte == $past(mem_data)));

   assert_chain_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && pend_full) |=> stall);

   assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && !fetch_req) |=> !stall);

   assert_slot_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pend_full |-> stall);

endmodule

bind fetch_stall_arb fsa_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fetch_req (fetch_req),
   .stall     (stall),
   .mem_rd    (mem_rd),
   .mem_addr  (mem_addr),
   .buf_load  (buf_load),
   .buf_byte  (buf_byte),
   .mem_data  (mem_data),
   .pend_full (pend_full)
);

// File: tb/sim_fetch_stall_arb.sv
`timescale 1ns/1ps
module sim_fetch_stall_arb;

   function automatic logic [7:0] dfun(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   function automatic int exp_len(input logic sb, input logic [8:0] left,
                                  input logic wr, input logic [15:0] wa);
      if (sb) return (left == 9'd2) ? 1 : ((left == 9'd1) ? 3 : 2);
      if (wr) return (wa == 16'h4014) ? 2 : 3;
      return 4;
   endfunction

   function automatic string exp_tag(input logic sb, input logic [8:0] left,
                                     input logic wr, input logic [15:0] wa);
      if (sb) return (left == 9'd2) ? "R5" : ((left == 9'd1) ? "R6" : "R7");
      if (wr) return (wa == 16'h4014) ? "R3" : "R4";
      return "R2";
   endfunction

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_req = 1'b0;
   logic [15:0] fetch_addr = '0;
   logic        cpu_wr = 1'b0;
   logic [15:0] cpu_wr_addr = '0;
   logic        spr_busy = 1'b0;
   logic [8:0]  spr_left = '0;
   logic [7:0]  mem_data;
   logic        stall, mem_rd, buf_load;
   logic [15:0] mem_addr;
   logic [7:0]  buf_byte;

   int n_chk = 0;
   int n_fail = 0;

   assign mem_data = dfun(mem_addr);

   always #4 clk = ~clk;

   fetch_stall_arb u0 (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .cpu_wr(cpu_wr), .cpu_wr_addr(cpu_wr_addr), .spr_busy(spr_busy),
      .spr_left(spr_left), .mem_data(mem_data), .stall(stall), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .buf_load(buf_load), .buf_byte(buf_byte)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic one_req(input logic wr, input logic [15:0] wa, input logic sb,
                          input logic [8:0] left, input logic [15:0] fa);
      int n;
      string tg;
      n  = exp_len(sb, left, wr, wa);
      tg = exp_tag(sb, left, wr, wa);
      @(negedge clk);
      fetch_req = 1'b1; fetch_addr = fa; cpu_wr = wr; cpu_wr_addr = wa;
      spr_busy = sb; spr_left = left;
      @(negedge clk);
      fetch_req = 1'b0; cpu_wr = 1'b0; spr_busy = 1'b0;
      for (int i = 1; i <= n; i++) begin
         if (i > 1) @(negedge clk);
         chk(stall == 1'b1, tg, stall, 1);
         chk(mem_rd == (i == n), "R8", mem_rd, (i == n));
         if (i == n) chk(mem_addr == fa, "R8", mem_addr, fa);
      end
      @(negedge clk);
      chk(stall == 1'b0, tg, stall, 0);
      chk(buf_load == 1'b1, "R9", buf_load, 1);
      chk(buf_byte == dfun(fa), "R9", buf_byte, dfun(fa));
      @(negedge clk);
      chk(buf_load == 1'b0, "R9", buf_load, 0);
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd1234);
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(stall == 1'b0 && mem_rd == 1'b0 && buf_load == 1'b0, "R1",
          {stall, mem_rd, buf_load}, 0);
      rst_n = 1'b1;
      // R12: no request, no stall
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(stall == 1'b0 && buf_load == 1'b0, "R12", stall, 0);
      end
      chk(mem_rd == 1'b0, "R1", mem_rd, 0);

      // Directed cases, one per length class
      one_req(1'b0, 16'h0000, 1'b0, 9'd0,   16'hC123);   // R2
      one_req(1'b1, 16'h4014, 1'b0, 9'd0,   16'hC200);   // R3
      one_req(1'b1, 16'h2007, 1'b0, 9'd0,   16'hC3F1);   // R4
      one_req(1'b1, 16'h4014, 1'b1, 9'd2,   16'hD004);   // R5 priority over write
      one_req(1'b0, 16'h0000, 1'b1, 9'd1,   16'hD105);   // R6
      one_req(1'b0, 16'h0000, 1'b1, 9'd256, 16'hD206);   // R7
      one_req(1'b0, 16'h0000, 1'b1, 9'd0,   16'hD307);   // R7 zero left

      // R10 / R11: chained request, then a discarded one
      @(negedge clk);
      fetch_req = 1'b1; fetch_addr = 16'hE111;                       // A, length 4
      for (int k = 1; k <= 11; k++) begin
         @(negedge clk);
         chk(stall == (k <= 6), "R10", stall, (k <= 6));
         chk(mem_rd == (k == 4 || k == 6), "R10", mem_rd, (k == 4 || k == 6));
         chk(buf_load == (k == 5 || k == 7), "R11", buf_load, (k == 5 || k == 7));
         if (k == 4) chk(mem_addr == 16'hE111, "R10", mem_addr, 16'hE111);
         if (k == 6) chk(mem_addr == 16'hE222, "R10", mem_addr, 16'hE222);
         if (k == 5) chk(buf_byte == dfun(16'hE111), "R10", buf_byte, dfun(16'hE111));
         if (k == 7) chk(buf_byte == dfun(16'hE222), "R10", buf_byte, dfun(16'hE222));
         if (k == 1) begin                                            // B, length 2
            fetch_req = 1'b1; fetch_addr = 16'hE222; cpu_wr = 1'b1; cpu_wr_addr = 16'h4014;
         end else if (k == 2) begin                                   // C, slot full
            fetch_req = 1'b1; fetch_addr = 16'hE333; cpu_wr = 1'b1; cpu_wr_addr = 16'h1234;
         end else begin
            fetch_req = 1'b0; cpu_wr = 1'b0;
         end
      end

      // Random single requests
      for (int it = 0; it < 40; it++) begin
         logic        wr, sb;
         logic [15:0] wa, fa;
         logic [8:0]  left;
         wr   = 1'($urandom % 2);
         sb   = 1'($urandom % 2);
         wa   = ($urandom % 2) ? 16'h4014 : 16'($urandom);
         left = ($urandom % 2) ? 9'($urandom % 4) : 9'($urandom);
         fa   = 16'($urandom);
         one_req(wr, wa, sb, left, fa);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired R12 actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule